// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and drives two active-high request lines: a normal request and a fast request. Each source line is registered into a level vector. Two separate enable masks, one per output, select which sources may raise each output. Each output is the OR of the level vector ANDed with its own mask. The block does no priority encoding, no vectoring and no edge capture. Software reads back the masked state to find which source is pending.

Software uses a word-addressed register port. Each enable mask has a set word and a clear word, both write-one, so one source can be enabled or disabled without a read-modify-write. Source line 0 also has a software latch. Software sets or clears the latch through its own two words. The latch is ORed with hardware input 0, so a test interrupt can be raised with no hardware event. Word addresses that the map does not use read as zero and ignore writes.

Top module: `dual_irq_ctrl`

## Requirements
- R1: A synchronous reset clears both enable masks, the software latch and the registered source levels. The request outputs are low in the cycle after reset.
- R2: Level bit n equals hardware input n as sampled at the previous clock edge. The raw level reads back at word 1 and also at word 9.
- R3: A write to word 2 ORs the written bits into the normal-request mask. A write to word 3 clears the written bits from it. Word 2 reads back the mask.
- R4: Words 10 and 11 set and clear the fast-request mask in the same way. Word 10 reads back the mask.
- R5: A write to word 4 with data bit 0 high sets the software latch. A write to word 5 with data bit 0 high clears it. Writes to these words with bit 0 low do nothing. Word 4 reads level bit 0 in bit 0 and zero in every other bit.
- R6: Level bit 0 is the OR of the latch and hardware input 0. A hardware deassertion never clears a latch that is set, and clearing the latch never hides an asserted hardware input 0.
- R7: Word 0 reads the level AND the normal-request mask. Word 8 reads the level AND the fast-request mask.
- R8: irq_o is high exactly when the level AND the normal-request mask is nonzero. fiq_o is high exactly when the level AND the fast-request mask is nonzero. Both outputs reflect a write or an input change in the following cycle.
- R9: A read of the write-only words 3, 5 and 11, or of any unused word (6, 7, 12 to 15), returns zero. When rd_en is low, rdata is zero.
- R10: Writes to the status words 0, 1, 8 and 9, and to unused words, change no mask and no latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the same cycle as rd_en |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench checks that each set/clear pair changes only the written bits. A design that assigned instead of ORing would lose earlier enables, and the masked status would then read back wrong. It checks that a hardware drop on source 0 leaves the software latch set, and that a software clear leaves an asserted hardware input 0 visible. A design that merged the two into one flop would fail one of those reads. It also reads the write-only and unused words and writes the status words: a decoder that aliased them would return nonzero data or change a mask. A reset in the middle of a run, with the masks loaded, must clear everything.

// File: rtl/dirq_pkg.sv
// Package: word map and class constants shared by the controller blocks.
// Assumes a word address of at least four bits. Bit 3 of the address selects
// the output class, and bits 2:0 select the register inside the class.
package dirq_pkg;
    localparam int unsigned NUM_CLASS    = 2;  // normal and fast request
    localparam int unsigned CLS_NORMAL   = 0;
    localparam int unsigned CLS_FAST     = 1;
    localparam int unsigned CLASS_STRIDE = 8;  // words between class banks
    localparam int unsigned SUB_W        = 3;  // in-bank word index width

    // Offsets inside one class bank
    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_RAW    = 1;
    localparam int unsigned OFS_EN_SET = 2;
    localparam int unsigned OFS_EN_CLR = 3;

    // Software latch words, present in the normal bank only
    localparam int unsigned W_SW_SET = 4;
    localparam int unsigned W_SW_CLR = 5;
endpackage

// File: rtl/dirq_level_track.sv
// Module: registers the hardware sources and keeps the software latch for
// line 0. Its output is the level vector that both request classes mask.
// Assumes NUM_SRC >= 2 and that set and clear strobes are never high together.
module dirq_level_track #(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               sw_set_i,
    input  logic               sw_clr_i,
    output logic [NUM_SRC-1:0] level_o
);
    logic [NUM_SRC-1:0] hw_q;
    logic               sw_q;

    // Sample the hardware levels once per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) hw_q <= '0;
        else        hw_q <= src_i;
    end

    // Software latch for line 0, written through the set and clear words
    always_ff @(posedge clk) begin
        if (!rst_n)        sw_q <= 1'b0;
        else if (sw_set_i) sw_q <= 1'b1;
        else if (sw_clr_i) sw_q <= 1'b0;
    end

    // Line 0 combines the latch with the hardware input
    always_comb level_o = hw_q | NUM_SRC'(sw_q);

    // R2: upper levels track the inputs with one cycle of delay
    a_r2_level_tracks_input: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> level_o[NUM_SRC-1:1] == $past(src_i[NUM_SRC-1:1]));

    // R5: a software set shows on line 0 in the next cycle
    a_r5_sw_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_i |=> level_o[0]);

    // R6: a set latch survives any hardware movement until it is cleared
    a_r6_latch_survives_hw_drop: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q && !sw_clr_i |=> level_o[0]);

    // R6: clearing the latch does not hide an asserted hardware line 0
    a_r6_hw_kept_after_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr_i && src_i[0] |=> level_o[0]);
endmodule

// File: rtl/dirq_mask_reg.sv
// Module: one enable mask with write-one-to-set and write-one-to-clear
// strobes. Assumes the set and clear strobes are never high in one cycle.
module dirq_mask_reg #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] en_o
);
    logic [WIDTH-1:0] set_bits;
    logic [WIDTH-1:0] clr_bits;

    // Gate the write data by the strobes
    always_comb begin
        set_bits = set_i ? d_i : '0;
        clr_bits = clr_i ? d_i : '0;
    end

    // Hold the mask and apply the set/clear updates
    always_ff @(posedge clk) begin
        if (!rst_n) en_o <= '0;
        else        en_o <= (en_o | set_bits) & ~clr_bits;
    end

    // R3 and R4: set raises every written bit and keeps the others
    a_r3_r4_set_ors_in: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> ((en_o & $past(d_i)) == $past(d_i)) &&
                  ((en_o & ~$past(d_i)) == ($past(en_o) & ~$past(d_i))));

    // R3 and R4: clear drops every written bit and keeps the others
    a_r3_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((en_o & $past(d_i)) == '0) &&
                  ((en_o & ~$past(d_i)) == ($past(en_o) & ~$past(d_i))));

    // R10: with no strobe the mask holds
    a_r10_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i && !clr_i |=> $stable(en_o));
endmodule

// File: rtl/dirq_read_mux.sv
// Module: read-data selection for the word map. Bit 3 of the address picks
// the class bank and bits 2:0 pick the register. Address bits above bit 3
// must be zero for a hit. Returns zero for every other word and when idle.
module dirq_read_mux #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     rd_en,
    input  logic [ADDR_W-1:0]                        addr,
    input  logic [NUM_SRC-1:0]                       level_i,
    input  logic [dirq_pkg::NUM_CLASS-1:0][NUM_SRC-1:0] en_i,
    output logic [DATA_W-1:0]                        rdata_o
);
    import dirq_pkg::*;

    localparam int unsigned BANK_LSB = SUB_W + 1;

    logic             in_range;
    logic             cls;
    logic [SUB_W-1:0] sub;
    logic [NUM_SRC-1:0] sel_en;

    // Split the word address into bank and in-bank index
    always_comb begin
        in_range = (addr >> BANK_LSB) == '0;
        cls      = addr[SUB_W];
        sub      = addr[SUB_W-1:0];
        sel_en   = cls ? en_i[CLS_FAST] : en_i[CLS_NORMAL];
    end

    // Select the word being read
    always_comb begin
        rdata_o = '0;
        if (rd_en && in_range) begin
            case (sub)
                SUB_W'(OFS_STATUS): rdata_o = DATA_W'(level_i & sel_en);
                SUB_W'(OFS_RAW):    rdata_o = DATA_W'(level_i);
                SUB_W'(OFS_EN_SET): rdata_o = DATA_W'(sel_en);
                SUB_W'(W_SW_SET):   rdata_o = cls ? '0 : DATA_W'(level_i[0]);
                default:            rdata_o = '0;
            endcase
        end
    end

    // R9: write-only and unused words read as zero
    a_r9_write_only_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == ADDR_W'(OFS_EN_CLR) || addr == ADDR_W'(W_SW_CLR) ||
                  addr == ADDR_W'(CLASS_STRIDE + OFS_EN_CLR)) |-> rdata_o == '0);

    // R9: no data is driven while no read is requested
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata_o == '0);

    // R7: a status read never shows a source outside its class mask
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_status_chk
        a_r7_status_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en && addr == ADDR_W'(c * CLASS_STRIDE + OFS_STATUS)
            |-> (rdata_o & ~DATA_W'(en_i[c])) == '0);
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
// Module: top of the dual-output level interrupt controller. It decodes
// register writes into mask and latch strobes, instantiates one mask per
// output class, and combines the registered level with each mask.
// Assumes NUM_SRC <= DATA_W, ADDR_W >= 4 and at most one access per cycle.
module dual_irq_ctrl #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    import dirq_pkg::*;

    logic [NUM_SRC-1:0]                level;
    logic [NUM_CLASS-1:0][NUM_SRC-1:0] en;
    logic [NUM_CLASS-1:0]              set_stb;
    logic [NUM_CLASS-1:0]              clr_stb;
    logic [NUM_CLASS-1:0]              req;
    logic                              sw_set;
    logic                              sw_clr;
    logic [NUM_SRC-1:0]                wbits;

    // Software latch strobes need data bit 0
    always_comb begin
        sw_set = wr_en && addr == ADDR_W'(W_SW_SET) && wdata[0];
        sw_clr = wr_en && addr == ADDR_W'(W_SW_CLR) && wdata[0];
        wbits  = wdata[NUM_SRC-1:0];
    end

    dirq_level_track #(.NUM_SRC(NUM_SRC)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .sw_set_i (sw_set),
        .sw_clr_i (sw_clr),
        .level_o  (level)
    );

    // One mask, decode and request combiner per output class
    for (genvar c = 0; c < NUM_CLASS; c++) begin : g_class
        // Decode the set and clear words of this class bank
        always_comb begin
            set_stb[c] = wr_en && addr == ADDR_W'(c * CLASS_STRIDE + OFS_EN_SET);
            clr_stb[c] = wr_en && addr == ADDR_W'(c * CLASS_STRIDE + OFS_EN_CLR);
        end

        dirq_mask_reg #(.WIDTH(NUM_SRC)) u_mask (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_stb[c]),
            .clr_i (clr_stb[c]),
            .d_i   (wbits),
            .en_o  (en[c])
        );

        // A request is pending when any enabled source is high
        always_comb req[c] = |(level & en[c]);

        // R8: clearing the whole mask silences this output next cycle
        a_r8_clear_all_silences: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && addr == ADDR_W'(c * CLASS_STRIDE + OFS_EN_CLR) && wbits == '1
            |=> !req[c]);
    end

    // Drive the two request pins
    always_comb begin
        irq_o = req[CLS_NORMAL];
        fiq_o = req[CLS_FAST];
    end

    dirq_read_mux #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .addr    (addr),
        .level_i (level),
        .en_i    (en),
        .rdata_o (rdata)
    );

    // R1: both outputs are low right after a reset cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !irq_o && !fiq_o);

    // R10: writes to the status words leave both masks alone
    a_r10_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr == ADDR_W'(OFS_STATUS) || addr == ADDR_W'(OFS_RAW) ||
                  addr == ADDR_W'(CLASS_STRIDE + OFS_STATUS) ||
                  addr == ADDR_W'(CLASS_STRIDE + OFS_RAW))
        |=> $stable(en));

    // R8: a request can only rise when some mask has a set bit
    a_r8_no_request_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> (en != '0));
endmodule

// File: tb/sim_dual_irq_ctrl.sv
// Bench: a vector table walked by one loop, then directed reset and
// software-latch tests. Each step drives at the falling edge and samples
// 2 ns later, so each sample shows the effect of every earlier step.
module sim_dual_irq_ctrl;
    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_WR   = 2'd1;
    localparam logic [1:0] OP_RD   = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] data;  // write data, or expected read data
        logic [31:0] src;
        logic        eirq;
        logic        efiq;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 35;
    localparam row_t TBL [NROWS] = '{
        '{OP_IDLE, 4'd0,  32'h0,        32'h0,        1'b0, 1'b0, 4'd1},  // R1 quiet
        '{OP_RD,   4'd1,  32'h0,        32'h000000F0, 1'b0, 1'b0, 4'd2},  // R2 not yet
        '{OP_RD,   4'd1,  32'h000000F0, 32'h000000F0, 1'b0, 1'b0, 4'd2},  // R2 raw
        '{OP_RD,   4'd9,  32'h000000F0, 32'h000000F0, 1'b0, 1'b0, 4'd2},  // R2 alias
        '{OP_RD,   4'd0,  32'h0,        32'h000000F0, 1'b0, 1'b0, 4'd7},  // R7 no mask
        '{OP_WR,   4'd2,  32'h00000030, 32'h000000F0, 1'b0, 1'b0, 4'd3},
        '{OP_RD,   4'd2,  32'h00000030, 32'h000000F0, 1'b1, 1'b0, 4'd3},  // R3 R8
        '{OP_RD,   4'd0,  32'h00000030, 32'h000000F0, 1'b1, 1'b0, 4'd7},  // R7
        '{OP_WR,   4'd2,  32'h01000000, 32'h000000F0, 1'b1, 1'b0, 4'd3},
        '{OP_RD,   4'd2,  32'h01000030, 32'h000000F0, 1'b1, 1'b0, 4'd3},  // R3 ors
        '{OP_WR,   4'd3,  32'h00000010, 32'h000000F0, 1'b1, 1'b0, 4'd3},
        '{OP_RD,   4'd2,  32'h01000020, 32'h000000F0, 1'b1, 1'b0, 4'd3},  // R3 clear
        '{OP_WR,   4'd3,  32'h00000020, 32'h000000F0, 1'b1, 1'b0, 4'd3},
        '{OP_RD,   4'd0,  32'h0,        32'h000000F0, 1'b0, 1'b0, 4'd8},  // R8 drop
        '{OP_WR,   4'd10, 32'h00000080, 32'h000000F0, 1'b0, 1'b0, 4'd4},
        '{OP_RD,   4'd10, 32'h00000080, 32'h000000F0, 1'b0, 1'b1, 4'd4},  // R4 R8
        '{OP_RD,   4'd8,  32'h00000080, 32'h000000F0, 1'b0, 1'b1, 4'd7},  // R7 fast
        '{OP_WR,   4'd11, 32'hFFFFFFFF, 32'h000000F0, 1'b0, 1'b1, 4'd4},
        '{OP_RD,   4'd10, 32'h0,        32'h000000F0, 1'b0, 1'b0, 4'd4},  // R4 clear
        '{OP_IDLE, 4'd0,  32'h0,        32'h01000000, 1'b0, 1'b0, 4'd8},
        '{OP_RD,   4'd1,  32'h01000000, 32'h01000000, 1'b1, 1'b0, 4'd8},  // R8 input
        '{OP_WR,   4'd0,  32'hFFFFFFFF, 32'h01000000, 1'b1, 1'b0, 4'd10},
        '{OP_WR,   4'd1,  32'hFFFFFFFF, 32'h01000000, 1'b1, 1'b0, 4'd10},
        '{OP_WR,   4'd8,  32'hFFFFFFFF, 32'h01000000, 1'b1, 1'b0, 4'd10},
        '{OP_WR,   4'd9,  32'hFFFFFFFF, 32'h01000000, 1'b1, 1'b0, 4'd10},
        '{OP_RD,   4'd2,  32'h01000000, 32'h01000000, 1'b1, 1'b0, 4'd10}, // R10
        '{OP_RD,   4'd10, 32'h0,        32'h01000000, 1'b1, 1'b0, 4'd10}, // R10
        '{OP_RD,   4'd1,  32'h01000000, 32'h01000000, 1'b1, 1'b0, 4'd10}, // R10
        '{OP_RD,   4'd3,  32'h0,        32'h01000000, 1'b1, 1'b0, 4'd9},  // R9
        '{OP_RD,   4'd5,  32'h0,        32'h01000000, 1'b1, 1'b0, 4'd9},  // R9
        '{OP_RD,   4'd11, 32'h0,        32'h01000000, 1'b1, 1'b0, 4'd9},  // R9
        '{OP_RD,   4'd7,  32'h0,        32'h01000000, 1'b1, 1'b0, 4'd9},  // R9
        '{OP_RD,   4'd15, 32'h0,        32'h01000000, 1'b1, 1'b0, 4'd9},  // R9
        '{OP_WR,   4'd3,  32'hFFFFFFFF, 32'h0,        1'b1, 1'b0, 4'd3},
        '{OP_RD,   4'd0,  32'h0,        32'h0,        1'b0, 1'b0, 4'd8}   // R8 all off
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_i;
    logic        wr_en, rd_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq_o, fiq_o;

    logic [31:0] s_rdata;
    logic        s_irq, s_fiq;
    int          total = 0;
    int          bad   = 0;

    always #10 clk = ~clk;  // 50 MHz

    dual_irq_ctrl u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src_i),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq_o (irq_o),
        .fiq_o (fiq_o)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample, advance a cycle
    task automatic step(input logic [1:0] op, input logic [3:0] a,
                        input logic [31:0] d, input logic [31:0] s);
        src_i = s;
        addr  = a;
        wdata = d;
        wr_en = (op == OP_WR);
        rd_en = (op == OP_RD);
        #2;
        s_rdata = rdata;
        s_irq   = irq_o;
        s_fiq   = fiq_o;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; src_i = '0; wr_en = 1'b0; rd_en = 1'b0;
        addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: state after reset
        step(OP_RD, 4'd2, 32'h0, 32'h0);
        check(1, "normal mask after reset", s_rdata, 32'h0);
        check(1, "irq after reset", 32'(s_irq), 32'h0);
        check(1, "fiq after reset", 32'(s_fiq), 32'h0);
        step(OP_RD, 4'd10, 32'h0, 32'h0);
        check(1, "fast mask after reset", s_rdata, 32'h0);
        step(OP_RD, 4'd1, 32'h0, 32'h0);
        check(1, "level after reset", s_rdata, 32'h0);
        step(OP_RD, 4'd4, 32'h0, 32'h0);
        check(1, "latch after reset", s_rdata, 32'h0);

        // Vector table walk
        for (int i = 0; i < NROWS; i++) begin
            step(TBL[i].op, TBL[i].addr, TBL[i].data, TBL[i].src);
            check(int'(TBL[i].req), $sformatf("row %0d irq", i), 32'(s_irq), 32'(TBL[i].eirq));
            check(int'(TBL[i].req), $sformatf("row %0d fiq", i), 32'(s_fiq), 32'(TBL[i].efiq));
            if (TBL[i].op == OP_RD)
                check(int'(TBL[i].req), $sformatf("row %0d rdata", i), s_rdata, TBL[i].data);
        end

        // R9: idle port returns zero
        step(OP_IDLE, 4'd1, 32'h0, 32'hFFFFFFFF);
        step(OP_IDLE, 4'd1, 32'h0, 32'hFFFFFFFF);
        check(9, "rdata with rd_en low", s_rdata, 32'h0);

        // R1: reset in mid-run with loaded masks
        step(OP_WR, 4'd2, 32'hFFFFFFFF, 32'hFFFFFFFF);
        step(OP_WR, 4'd10, 32'hFFFFFFFF, 32'hFFFFFFFF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(OP_RD, 4'd2, 32'h0, 32'h0);
        check(1, "normal mask after mid reset", s_rdata, 32'h0);
        check(1, "irq after mid reset", 32'(s_irq), 32'h0);
        check(1, "fiq after mid reset", 32'(s_fiq), 32'h0);
        step(OP_RD, 4'd10, 32'h0, 32'h0);
        check(1, "fast mask after mid reset", s_rdata, 32'h0);

        // R5 and R6: software latch on line 0
        step(OP_WR, 4'd2, 32'h1, 32'h0);
        step(OP_WR, 4'd4, 32'hFFFFFFFE, 32'h0);
        step(OP_RD, 4'd4, 32'h0, 32'h0);
        check(5, "set word with bit 0 low", s_rdata, 32'h0);
        check(5, "irq with latch idle", 32'(s_irq), 32'h0);
        step(OP_WR, 4'd4, 32'h1, 32'h0);
        step(OP_RD, 4'd4, 32'h0, 32'h0);
        check(5, "latch set readback", s_rdata, 32'h1);
        check(8, "irq from latch", 32'(s_irq), 32'h1);
        step(OP_RD, 4'd1, 32'h0, 32'h0);
        check(5, "raw level with latch", s_rdata, 32'h1);
        step(OP_WR, 4'd5, 32'hFFFFFFFE, 32'h0);
        step(OP_RD, 4'd4, 32'h0, 32'h0);
        check(5, "clear word with bit 0 low", s_rdata, 32'h1);
        step(OP_IDLE, 4'd0, 32'h0, 32'h1);
        step(OP_IDLE, 4'd0, 32'h0, 32'h0);
        step(OP_RD, 4'd4, 32'h0, 32'h0);
        check(6, "latch after hw drop", s_rdata, 32'h1);
        check(6, "irq after hw drop", 32'(s_irq), 32'h1);
        step(OP_IDLE, 4'd0, 32'h0, 32'h1);
        step(OP_WR, 4'd5, 32'h1, 32'h1);
        step(OP_RD, 4'd4, 32'h0, 32'h1);
        check(6, "hw line 0 after sw clear", s_rdata, 32'h1);
        check(6, "irq held by hw", 32'(s_irq), 32'h1);
        step(OP_IDLE, 4'd0, 32'h0, 32'h0);
        step(OP_RD, 4'd4, 32'h0, 32'h0);
        check(5, "line 0 fully cleared", s_rdata, 32'h0);
        check(8, "irq after clear", 32'(s_irq), 32'h0);
        step(OP_IDLE, 4'd0, 32'h0, 32'h000000F0);
        step(OP_RD, 4'd4, 32'h0, 32'h000000F0);
        check(5, "soft word hides upper bits", s_rdata, 32'h0);
        step(OP_RD, 4'd1, 32'h0, 32'h000000F0);
        check(2, "raw level upper bits", s_rdata, 32'h000000F0);
        step(OP_RD, 4'd12, 32'h0, 32'h000000F0);
        check(9, "fast bank soft word unused", s_rdata, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule